// File: doc/BRIEF.md
# Two-Rule Weighted-Average Defuzzifier

This block turns the result of two fired fuzzy rules into one crisp value. Each rule supplies two antecedent membership degrees and the two support points of a symmetric trapezoidal consequent. An AND (minimum) stage gives each rule its strength. Each consequent's centre is the midpoint of its support. The crisp output is the average of the two centres, with each centre weighted by its rule's strength.

Two multipliers work in parallel to build the numerator. A separate adder builds the denominator. A sequential restoring divider then produces the quotient. The caller presents eight unsigned values with `in_valid` while `in_ready` is high. Some cycles later the block returns the crisp result with a one-cycle `out_valid`. A new set can be applied in each evaluation slot. Membership degrees are scaled integers; for example, 0.25, 0.5 and 0.75 are carried as 5, 10 and 15.

Top module: `wavg_defuzz`

## Requirements
- R1: Each rule strength equals the smaller of its two antecedent degrees. When one rule has strength zero, the output equals the other rule's centre.
- R2: Each centre equals lo + (hi - lo)/2, truncated, where lo and hi are the smaller and larger of the two support points. A support given with its points in reverse order yields the same centre as the ordered support.
- R3: With N = CC1*T1 + CC2*T2 and D = T1 + T2, `out_crisp` equals N/D truncated toward zero.
- R4: When both strengths are zero, `out_crisp` is 0 and `out_none` is 1 for that result.
- R5: `in_valid` is ignored while `in_ready` is low, so the inputs seen by the block cannot change during an evaluation.
- R6: After reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` drops in the cycle after an input set is accepted and stays low until the result has been delivered. `out_valid` is high for exactly one cycle per accepted set.
- R7: `out_none` is 0 for every result whose denominator is nonzero.
- R8: Three sets applied back to back return their results in order. Degrees 10/10, 5/10 with supports 0..8 and 4..16 give 6. Degrees 5/10, 15/10 with supports 0..8 and 6..14 give 8. Equal strengths with centres 4 and 10 give 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input set present |
| in_ready | output | 1 | Block can accept a set |
| deg_a1 | input | 8 | Rule 1 first antecedent degree |
| deg_b1 | input | 8 | Rule 1 second antecedent degree |
| deg_a2 | input | 8 | Rule 2 first antecedent degree |
| deg_b2 | input | 8 | Rule 2 second antecedent degree |
| c1_lo | input | 8 | Rule 1 consequent left support point |
| c1_hi | input | 8 | Rule 1 consequent right support point |
| c2_lo | input | 8 | Rule 2 consequent left support point |
| c2_hi | input | 8 | Rule 2 consequent right support point |
| out_valid | output | 1 | One-cycle result strobe |
| out_crisp | output | 8 | Crisp result |
| out_none | output | 1 | No rule fired (both strengths zero) |

## Verification
The assertions assume that inputs change only at accepted handshakes, or that changes made while `in_ready` is low are not latched. They also assume that a weighted average of two 8-bit centres always fits in 8 bits, so the upper quotient bits stay zero. The stimulus keeps to this by driving data only through a handshake task that waits for `in_ready`. Any extra `in_valid` pokes are made only in the middle of a long division. Random degrees and supports span the full 8-bit range, including reversed supports. Zero strengths are forced on purpose to reach the empty-denominator case.

// File: rtl/wad_pkg.sv
package wad_pkg;

    typedef enum logic [1:0] {
        TOP_IDLE,
        TOP_LOAD,
        TOP_WAIT
    } top_st_e;

    typedef enum logic {
        DIV_IDLE,
        DIV_RUN
    } div_st_e;

    // midpoint of a support whose ends may arrive in either order
    function automatic int unsigned wad_mid(int unsigned p, int unsigned q);
        int unsigned lo;
        int unsigned hi;
        lo = (p < q) ? p : q;
        hi = (p < q) ? q : p;
        return lo + ((hi - lo) >> 1);
    endfunction

endpackage

// File: rtl/wad_rule.sv
module wad_rule #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] deg_a,
    input  logic [DW-1:0] deg_b,
    input  logic [DW-1:0] sup_lo,
    input  logic [DW-1:0] sup_hi,
    output logic [DW-1:0] strength,
    output logic [DW-1:0] centre
);
    import wad_pkg::*;

    always_comb begin
        strength = (deg_a < deg_b) ? deg_a : deg_b;
        centre   = DW'(wad_mid(32'(sup_lo), 32'(sup_hi)));
    end

    // R1
    strength_min_chk: assert property (@(posedge clk) disable iff (rst)
        (strength <= deg_a) && (strength <= deg_b) && ((strength == deg_a) || (strength == deg_b)));

    // R2
    centre_in_support_chk: assert property (@(posedge clk) disable iff (rst)
        ((centre >= sup_lo) || (centre >= sup_hi)) && ((centre <= sup_lo) || (centre <= sup_hi)));

endmodule

// File: rtl/wad_accum.sv
module wad_accum #(
    parameter int unsigned DW = 8,
    parameter int unsigned NR = 2,
    localparam int unsigned PW = 2 * DW,
    localparam int unsigned NW = PW + $clog2(NR),
    localparam int unsigned EW = DW + $clog2(NR)
) (
    input  logic [NR-1:0][DW-1:0] str,
    input  logic [NR-1:0][DW-1:0] cen,
    output logic [NW-1:0]         num,
    output logic [EW-1:0]         den
);
    logic [NR-1:0][PW-1:0] prod;

    // one multiplier per rule, all in parallel
    for (genvar i = 0; i < NR; i++) begin : g_mul
        assign prod[i] = PW'(str[i]) * PW'(cen[i]);
    end

    always_comb begin
        num = '0;
        den = '0;
        for (int i = 0; i < NR; i++) begin
            num = num + NW'(prod[i]);
            den = den + EW'(str[i]);
        end
    end

endmodule

// File: rtl/wad_div.sv
module wad_div #(
    parameter int unsigned NW = 17,
    parameter int unsigned EW = 9,
    parameter int unsigned QW = 8,
    localparam int unsigned RW = EW + 1,
    localparam int unsigned CW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [EW-1:0] den,
    output logic          busy,
    output logic          done,
    output logic [QW-1:0] quo,
    output logic          none
);
    import wad_pkg::*;

    div_st_e       st;
    logic [RW-1:0] rem;
    logic [NW-1:0] q;
    logic [EW-1:0] den_q;
    logic [CW-1:0] cnt;

    logic [RW-1:0] rem_sh;
    logic          ge;
    logic [RW-1:0] rem_nx;
    logic [NW-1:0] q_nx;

    always_comb begin
        rem_sh = {rem[RW-2:0], q[NW-1]};
        ge     = rem_sh >= RW'(den_q);
        rem_nx = ge ? (rem_sh - RW'(den_q)) : rem_sh;
        q_nx   = {q[NW-2:0], ge};
    end

    assign busy = (st == DIV_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= DIV_IDLE;
            rem   <= '0;
            q     <= '0;
            den_q <= '0;
            cnt   <= '0;
            done  <= 1'b0;
            quo   <= '0;
            none  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                DIV_IDLE: begin
                    if (start) begin
                        if (den == '0) begin
                            done <= 1'b1;
                            quo  <= '0;
                            none <= 1'b1;
                        end else begin
                            rem   <= '0;
                            q     <= num;
                            den_q <= den;
                            cnt   <= CW'(NW);
                            st    <= DIV_RUN;
                        end
                    end
                end
                default: begin
                    rem <= rem_nx;
                    q   <= q_nx;
                    cnt <= cnt - 1'b1;
                    if (cnt == CW'(1)) begin
                        done <= 1'b1;
                        quo  <= q_nx[QW-1:0];
                        none <= 1'b0;
                        st   <= DIV_IDLE;
                    end
                end
            endcase
        end
    end

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem < RW'(den_q)));

    // R3
    quo_fits_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == CW'(1)) |-> (q_nx[NW-1:QW] == '0));

endmodule

// File: rtl/wavg_defuzz.sv
module wavg_defuzz #(
    parameter int unsigned DW = 8,
    localparam int unsigned NR = 2,
    localparam int unsigned NW = 2 * DW + $clog2(NR),
    localparam int unsigned EW = DW + $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] deg_a1,
    input  logic [DW-1:0] deg_b1,
    input  logic [DW-1:0] deg_a2,
    input  logic [DW-1:0] deg_b2,
    input  logic [DW-1:0] c1_lo,
    input  logic [DW-1:0] c1_hi,
    input  logic [DW-1:0] c2_lo,
    input  logic [DW-1:0] c2_hi,
    output logic          out_valid,
    output logic [DW-1:0] out_crisp,
    output logic          out_none
);
    import wad_pkg::*;

    top_st_e st;

    logic [NR-1:0][DW-1:0] a_q, b_q, lo_q, hi_q;
    logic [NR-1:0][DW-1:0] str, cen;
    logic [NW-1:0]         num;
    logic [EW-1:0]         den;
    logic                  div_busy;
    logic                  div_start;

    assign in_ready  = (st == TOP_IDLE);
    assign div_start = (st == TOP_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TOP_IDLE;
            a_q  <= '0;
            b_q  <= '0;
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            case (st)
                TOP_IDLE: begin
                    if (in_valid) begin
                        a_q  <= {deg_a2, deg_a1};
                        b_q  <= {deg_b2, deg_b1};
                        lo_q <= {c2_lo, c1_lo};
                        hi_q <= {c2_hi, c1_hi};
                        st   <= TOP_LOAD;
                    end
                end
                TOP_LOAD: st <= TOP_WAIT;
                default:  if (out_valid) st <= TOP_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < NR; i++) begin : g_rule
        wad_rule #(.DW(DW)) rule_i (
            .clk      (clk),
            .rst      (rst),
            .deg_a    (a_q[i]),
            .deg_b    (b_q[i]),
            .sup_lo   (lo_q[i]),
            .sup_hi   (hi_q[i]),
            .strength (str[i]),
            .centre   (cen[i])
        );
    end

    wad_accum #(.DW(DW), .NR(NR)) accum_i (
        .str (str),
        .cen (cen),
        .num (num),
        .den (den)
    );

    wad_div #(.NW(NW), .EW(EW), .QW(DW)) div_i (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (num),
        .den   (den),
        .busy  (div_busy),
        .done  (out_valid),
        .quo   (out_crisp),
        .none  (out_none)
    );

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> !in_ready);

    // R4
    none_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_none) |-> (out_crisp == '0));

    // R5
    hold_inputs_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !out_valid) |=> $stable(a_q) && $stable(b_q) && $stable(lo_q) && $stable(hi_q));

endmodule

// File: tb/wavg_defuzz_tb_top.sv
module wavg_defuzz_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] deg_a1 = '0, deg_b1 = '0, deg_a2 = '0, deg_b2 = '0;
    logic [7:0] c1_lo = '0, c1_hi = '0, c2_lo = '0, c2_hi = '0;
    logic       out_valid;
    logic [7:0] out_crisp;
    logic       out_none;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wavg_defuzz dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .deg_a1(deg_a1), .deg_b1(deg_b1), .deg_a2(deg_a2), .deg_b2(deg_b2),
        .c1_lo(c1_lo), .c1_hi(c1_hi), .c2_lo(c2_lo), .c2_hi(c2_hi),
        .out_valid(out_valid), .out_crisp(out_crisp), .out_none(out_none)
    );

    function automatic int ref_mid(int p, int q);
        int lo = (p < q) ? p : q;
        int hi = (p < q) ? q : p;
        return lo + (hi - lo) / 2;
    endfunction

    function automatic int ref_min(int p, int q);
        return (p < q) ? p : q;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run_set(int a1, int b1, int a2, int b2,
                           int l1, int h1, int l2, int h2,
                           bit poke, string req);
        int t1 = ref_min(a1, b1);
        int t2 = ref_min(a2, b2);
        int nn = ref_mid(l1, h1) * t1 + ref_mid(l2, h2) * t2;
        int dd = t1 + t2;
        int exp_q = (dd == 0) ? 0 : nn / dd;
        int exp_n = (dd == 0) ? 1 : 0;
        int waited = 0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        deg_a1 = 8'(a1); deg_b1 = 8'(b1); deg_a2 = 8'(a2); deg_b2 = 8'(b2);
        c1_lo = 8'(l1); c1_hi = 8'(h1); c2_lo = 8'(l2); c2_hi = 8'(h2);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 in_ready low after accept", int'(in_ready), 0);
        if (poke) begin
            // R5: a new set offered mid-evaluation must not be taken
            deg_a1 = 8'hFF; deg_b1 = 8'hFF; deg_a2 = 8'h00; deg_b2 = 8'h00;
            c1_lo = 8'hF0; c1_hi = 8'hFF; c2_lo = 8'h01; c2_hi = 8'h02;
            in_valid = 1'b1;
            repeat (3) @(negedge clk);
            in_valid = 1'b0;
        end
        while (!out_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        if (!out_valid) begin
            check({req, " watchdog"}, 0, 1);
        end else begin
            check({req, " crisp"}, int'(out_crisp), exp_q);
            check({req, exp_n ? " R4 none flag" : " R7 none flag"}, int'(out_none), exp_n);
            @(negedge clk);
            check("R6 out_valid single pulse", int'(out_valid), 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        check("watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R6 reset in_ready", int'(in_ready), 1);
        check("R6 reset out_valid", int'(out_valid), 0);

        // R8 back-to-back directed sets, also R3
        run_set(10, 10, 5, 10, 0, 8, 4, 16, 0, "R8 set one");
        run_set(5, 10, 15, 10, 0, 8, 6, 14, 0, "R8 set two");
        run_set(10, 10, 10, 10, 0, 8, 6, 14, 0, "R8 set three");
        // R4 both strengths zero
        run_set(0, 9, 7, 0, 3, 200, 10, 20, 0, "R4 empty");
        // R1 one rule dead: output is other centre
        run_set(0, 50, 30, 40, 0, 100, 20, 40, 0, "R1 single rule");
        run_set(60, 20, 20, 60, 0, 10, 0, 30, 0, "R1 min pick");
        // R2 reversed supports
        run_set(10, 10, 5, 10, 8, 0, 16, 4, 0, "R2 swapped");
        run_set(7, 7, 7, 7, 255, 0, 9, 9, 0, "R2 odd range");
        // R5 ignored in_valid while busy
        run_set(5, 10, 15, 10, 0, 8, 6, 14, 1, "R5 ignored");
        // R3 extremes
        run_set(255, 255, 255, 255, 255, 255, 255, 255, 0, "R3 max");
        run_set(1, 1, 255, 255, 0, 0, 255, 255, 0, "R3 skewed");

        for (int i = 0; i < 200; i++) begin
            run_set(int'($urandom_range(255)), int'($urandom_range(255)),
                    int'($urandom_range(255)), int'($urandom_range(255)),
                    int'($urandom_range(255)), int'($urandom_range(255)),
                    int'($urandom_range(255)), int'($urandom_range(255)),
                    (i % 7) == 0, "R3 random");
        end
        finish_run();
    end

endmodule